// File: doc/BRIEF.md
# Memory Module Geometry Prober

This block determines the shape of an installed DRAM module by probing it through an access sequencer. Row and column addresses share the same number of bits, so a candidate width `n` implies a first-bank size of 2^(2n) bytes. The block tries candidate widths from the widest down. For each one it programs the sequencer's address-bit setting and probes the highest byte of the first bank with a fixed set of write-then-read byte patterns. The first candidate that passes sets the width. The byte just above that bank is then probed to find out whether a second row-strobe bank answers.

A pulse on `start` runs one detection. The block talks to the sequencer through a valid/ack request port that carries one byte access at a time. When detection ends it pulses `done` and publishes the width, the bank count and the capacity in bytes. If every candidate fails, it raises `fail` instead and keeps the previous results. The byte read back on the most recent mismatch is kept on `bad_data`.

Top module: `dram_geom_probe`

## Requirements
- R1: A probe of one address writes and then reads back, at that same address, the bytes 0xF0, 0x0F, 0xAA, 0x55, 0xC0, 0x30, 0x0C, 0x03 in that order. Each byte is read back before the next byte is written.
- R2: A probe stops at its first read-back mismatch, with no further writes to that address. The mismatching byte is latched on `bad_data` until the next mismatch.
- R3: The width search starts with candidate `MAX_BITS` (12). While candidate `n` is probed, `cfg_bits` equals `n` and the width probe address is 2^(2n)-1.
- R4: After a failed width probe the candidate drops by one. The lowest candidate tried is `MIN_BITS` (9). If that candidate also fails, `done` pulses with `fail`=1, and `geo_bits`, `geo_ras` and `geo_bytes` keep their previous values.
- R5: Once a width `n` passes, the address 2^(2n) is probed. `geo_ras` becomes 2 if that probe passes and 1 if it fails. `geo_bits` becomes `n`, and `fail` is 0.
- R6: `geo_bytes` equals 2^(2n) x 4 x `geo_ras` for the width `n` that was found.
- R7: `done` is high for exactly one cycle per detection. The results are valid in the cycle in which `done` is high.
- R8: A `start` pulse seen while `busy` is high has no effect. This includes the cycle in which the final read response arrives.
- R9: Once `rq_valid` is raised, it stays high, with address, data, direction and `cfg_bits` unchanged, until `rq_ack` is seen.
- R10: After reset, `busy`, `rq_valid`, `done` and `fail` are 0, and `geo_bits`, `geo_ras`, `geo_bytes` and `bad_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a detection when the block is idle |
| busy | output | 1 | Detection in progress |
| rq_valid | output | 1 | Access request to the sequencer |
| rq_we | output | 1 | 1 for a write access, 0 for a read access |
| rq_addr | output | 2*MAX_BITS+1 | Byte address of the access |
| rq_wdata | output | 8 | Write data |
| cfg_bits | output | clog2(MAX_BITS+1) | Address-bit setting given to the sequencer |
| rq_ack | input | 1 | Sequencer completes the current access |
| rq_rdata | input | 8 | Read data, valid with `rq_ack` on a read |
| geo_bits | output | clog2(MAX_BITS+1) | Detected row/column width |
| geo_ras | output | 2 | Detected bank count (1 or 2) |
| geo_bytes | output | 2*MAX_BITS+4 | Detected capacity in bytes |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No candidate width passed |
| bad_data | output | 8 | Byte read on the latest mismatch |

## Verification
Two events can fall in the same cycle: the sequencer's response to the final read-back of a detection, and a fresh `start` request. The bench watches its own count of completed writes. When it sees the last read of a known sixteen-write run being acknowledged, it raises `start` in exactly that cycle. The correct outcome is a single `done` pulse and no further requests afterwards, because the block was still busy when `start` arrived. A separate `start` pulse in the middle of a run must likewise leave the write count and the results unchanged.

// File: rtl/dram_geom_probe.sv
module dram_geom_probe #(
  parameter int MAX_BITS = 12,
  parameter int MIN_BITS = 9,
  localparam int AW   = 2*MAX_BITS + 1,
  localparam int CW   = $clog2(MAX_BITS + 1),
  localparam int CAPW = 2*MAX_BITS + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            rq_valid,
  output logic            rq_we,
  output logic [AW-1:0]   rq_addr,
  output logic [7:0]      rq_wdata,
  output logic [CW-1:0]   cfg_bits,
  input  logic            rq_ack,
  input  logic [7:0]      rq_rdata,
  output logic [CW-1:0]   geo_bits,
  output logic [1:0]      geo_ras,
  output logic [CAPW-1:0] geo_bytes,
  output logic            done,
  output logic            fail,
  output logic [7:0]      bad_data
);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} st_t;

  st_t         st;
  logic [CW-1:0] cand;
  logic [2:0]  pidx;
  logic        bank_ph;
  logic [7:0]  pat;
  logic [AW-1:0] bank_base;

  always_comb begin
    case (pidx)
      3'd0: pat = 8'hF0;
      3'd1: pat = 8'h0F;
      3'd2: pat = 8'hAA;
      3'd3: pat = 8'h55;
      3'd4: pat = 8'hC0;
      3'd5: pat = 8'h30;
      3'd6: pat = 8'h0C;
      default: pat = 8'h03;
    endcase
  end

  assign bank_base = AW'(1) << (2*cand);
  assign busy      = (st != S_IDLE);
  assign rq_valid  = busy;
  assign rq_we     = (st == S_WR);
  assign rq_wdata  = pat;
  assign cfg_bits  = cand;
  assign rq_addr   = bank_ph ? bank_base : bank_base - AW'(1);

  wire match = (rq_rdata == pat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cand      <= CW'(MAX_BITS);
      pidx      <= '0;
      bank_ph   <= 1'b0;
      geo_bits  <= '0;
      geo_ras   <= '0;
      geo_bytes <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      bad_data  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cand    <= CW'(MAX_BITS);
          pidx    <= '0;
          bank_ph <= 1'b0;
          fail    <= 1'b0;
          st      <= S_WR;
        end
        S_WR: if (rq_ack) st <= S_RD;
        S_RD: if (rq_ack) begin
          if (match && pidx != 3'd7) begin
            pidx <= pidx + 3'd1;
            st   <= S_WR;
          end else if (match && !bank_ph) begin
            pidx    <= '0;
            bank_ph <= 1'b1;
            st      <= S_WR;
          end else if (!match && !bank_ph && cand > CW'(MIN_BITS)) begin
            bad_data <= rq_rdata;
            pidx     <= '0;
            cand     <= cand - CW'(1);
            st       <= S_WR;
          end else if (!match && !bank_ph) begin
            bad_data <= rq_rdata;
            fail     <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            if (!match) bad_data <= rq_rdata;
            geo_bits  <= cand;
            geo_ras   <= match ? 2'd2 : 2'd1;
            geo_bytes <= CAPW'(1) << (2*cand + (match ? 3 : 2));
            done      <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ack |=> rq_valid && $stable(rq_addr) && $stable(rq_we)
                            && $stable(rq_wdata) && $stable(cfg_bits));

  // R1
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_we && rq_ack |=> rq_valid && !rq_we && $stable(rq_addr));

  // R3
  cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> cfg_bits <= CW'(MAX_BITS) && cfg_bits >= CW'(MIN_BITS));

  // R4
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/test_dram_geom_probe.sv
module test_dram_geom_probe;
  localparam int MAXB = 12;
  localparam int AW = 2*MAXB + 1;
  localparam int CW = $clog2(MAXB + 1);
  localparam int CAPW = 2*MAXB + 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, rq_valid, rq_we, rq_ack, done, fail;
  logic [AW-1:0] rq_addr;
  logic [7:0] rq_wdata, rq_rdata, bad_data;
  logic [CW-1:0] cfg_bits, geo_bits;
  logic [1:0] geo_ras;
  logic [CAPW-1:0] geo_bytes;

  always #10 clk = ~clk;

  dram_geom_probe i_dram_geom_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rq_valid(rq_valid), .rq_we(rq_we), .rq_addr(rq_addr), .rq_wdata(rq_wdata),
    .cfg_bits(cfg_bits), .rq_ack(rq_ack), .rq_rdata(rq_rdata),
    .geo_bits(geo_bits), .geo_ras(geo_ras), .geo_bytes(geo_bytes),
    .done(done), .fail(fail), .bad_data(bad_data));

  int checks = 0, fails = 0;
  int m_n = 12, m_r = 2, m_f = 0;
  logic [7:0] mem;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sequencer and module model: one-cycle ack, absent locations float to 0xFF
  wire m_valid = (int'(cfg_bits) <= m_n) && ((rq_addr >> (2*cfg_bits)) < AW'(m_r));
  always @(posedge clk) begin
    if (!rst_n) rq_ack <= 0;
    else begin
      rq_ack <= rq_valid && !rq_ack;
      if (rq_valid && !rq_ack) begin
        if (rq_we) begin
          if (m_valid) mem <= rq_wdata;
        end else
          rq_rdata <= m_valid ? (mem ^ ((int'(cfg_bits) == m_f && mem == 8'hAA) ? 8'h01 : 8'h00)) : 8'hFF;
      end
    end
  end

  // request monitor (sampled away from the active edge)
  int mon_wr = 0, mon_k = 0, mon_err = 0, done_cnt = 0, first_cfg = -1;
  logic [AW-1:0] last_wa;
  bit arm_race = 0;
  function automatic logic [7:0] exp_pat(input int k);
    case (k)
      0: return 8'hF0; 1: return 8'h0F; 2: return 8'hAA; 3: return 8'h55;
      4: return 8'hC0; 5: return 8'h30; 6: return 8'h0C; default: return 8'h03;
    endcase
  endfunction
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (rq_valid && rq_ack && rq_we) begin
      logic [AW-1:0] top;
      top = (AW'(1) << (2*cfg_bits)) - AW'(1);
      if (first_cfg < 0) first_cfg = int'(cfg_bits);
      if (mon_wr > 0 && rq_addr != last_wa) mon_k = 0;
      if (rq_wdata != exp_pat(mon_k)) mon_err++;
      if (rq_addr != top && rq_addr != top + AW'(1)) mon_err++;
      last_wa = rq_addr;
      mon_k++;
      mon_wr++;
    end
    if (rq_valid && rq_ack && !rq_we && rq_addr != last_wa) mon_err++;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic kick();
    mon_wr = 0; mon_k = 0; mon_err = 0; done_cnt = 0; first_cfg = -1;
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // n, ras, fault cfg, exp bits, exp ras, exp fail, exp writes, exp bad (-1 none)
  localparam int NV = 6;
  localparam int VEC [NV][8] = '{
    '{12, 2,  0, 12, 2, 0, 16,   -1},
    '{12, 1,  0, 12, 1, 0,  9, 'hFF},
    '{10, 2,  0, 10, 2, 0, 18, 'hFF},
    '{11, 2, 11, 10, 2, 0, 20, 'hAB},
    '{ 9, 1,  0,  9, 1, 0, 12, 'hFF},
    '{ 8, 1,  0,  9, 1, 1,  4, 'hFF}
  };

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0); chk("R10 rq_valid", rq_valid, 0);
    chk("R10 done", done, 0); chk("R10 fail", fail, 0);
    chk("R10 geo", {geo_bits, geo_ras, geo_bytes, bad_data}, 0);
    rst_n = 1; @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      m_n = VEC[v][0]; m_r = VEC[v][1]; m_f = VEC[v][2];
      kick();
      wait_done(ok);
      chk("R7 done seen", ok, 1);
      chk("R5 geo_bits", geo_bits, VEC[v][3]);
      chk("R5 geo_ras", geo_ras, VEC[v][4]);
      chk("R4 fail", fail, VEC[v][5]);
      chk("R6 geo_bytes", geo_bytes, (longint'(1) << (2*VEC[v][3])) * 4 * VEC[v][4]);
      chk("R2 write count", mon_wr, VEC[v][6]);
      if (VEC[v][7] >= 0) chk("R2 bad_data", bad_data, VEC[v][7]);
      chk("R1 pattern/address order", mon_err, 0);
      chk("R3 first cfg", first_cfg, MAXB);
      @(negedge clk);
      chk("R7 done one cycle", done, 0);
      chk("R7 single pulse", done_cnt, 1);
    end

    // R8: start pulsed mid-run is ignored
    m_n = 12; m_r = 2; m_f = 0;
    kick();
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done(ok);
    chk("R8 mid-run start writes", mon_wr, 16);
    @(negedge clk);
    chk("R8 mid-run start single done", done_cnt, 1);

    // R8: start in the cycle of the final read response is ignored
    kick();
    arm_race = 1;
    for (int i = 0; i < 3000; i++) begin
      if (rq_valid && rq_ack && !rq_we && mon_wr == 16) break;
      @(negedge clk);
    end
    start = 1; @(negedge clk); start = 0;
    chk("R7 done at final response", done, 1);
    repeat (10) begin
      @(negedge clk);
      if (rq_valid) mon_err++;
    end
    chk("R8 no restart after final response", mon_err, 0);
    chk("R8 final-response single done", done_cnt, 1);
    chk("R9 busy idle after race", busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule